// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block holds the byte registers of an 8-bit processor: an accumulator/flags pair and three general 16-bit pairs (BC, DE, HL), each kept in a primary and an alternate copy. It serves one 8-bit read port, one 16-bit pair read port, one 8-bit write port and one 16-bit pair write port. Every port is addressed by architectural register name, never by physical location.

Three one-cycle command inputs change how names reach storage. One swaps the live accumulator/flags copy. One swaps the live copy of the whole BC/DE/HL group. One swaps the roles of DE and HL. The instruction decoder raises the first two when it decodes the two exchange opcodes. Each command only toggles a select bit that steers addressing. No register contents ever move, so every exchange completes in a single clock.

Top module: `dual_bank_regfile`

## Requirements
- R1: After reset every register in both copies reads 0, the primary copy of both groups is live, and D, E, H and L are not role-swapped.
- R2: 8-bit names are coded B=0, C=1, D=2, E=3, H=4, L=5, F=6, A=7. The 8-bit read port returns the named live register combinationally. A byte written through the 8-bit write port is returned by that read from the cycle after the write edge.
- R3: Pair names are coded BC=0, DE=1, HL=2, AF=3. A pair read returns the high register (B, D, H or A) in bits 15:8 and the low register (C, E, L or F) in bits 7:0. A pair write stores bits 15:8 to the high register and bits 7:0 to the low register.
- R4: A pulse on xchg_af_i makes A and F reach the other copy from the next cycle on. BC, DE and HL are unaffected.
- R5: A pulse on xchg_gp_i makes B, C, D, E, H and L reach the other copy from the next cycle on. A and F are unaffected.
- R6: An exchange moves no data. Values written to one copy stay intact while the other copy is live, and two exchanges of a group restore the original view.
- R7: A write and an exchange issued in the same cycle store the data into the copy that was live before the exchange. The exchange then takes effect.
- R8: A pulse on xchg_dehl_i toggles a role swap. While it is set, the names D and E reach the storage of H and L, and H and L reach the storage of D and E, within the live copy. A write issued with the toggle uses the old mapping.
- R9: When the 8-bit write and the pair write hit the same byte in one cycle, the 8-bit data is stored there. The other byte of the pair still takes the pair data.
- R10: In a cycle with both write enables low, no register changes, whatever is on the write data and select inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd8_sel_i | input | 3 | 8-bit read register code |
| rd8_data_o | output | 8 | 8-bit read data |
| rd16_sel_i | input | 2 | Pair read code |
| rd16_data_o | output | 16 | Pair read data, high:low |
| wr8_en_i | input | 1 | 8-bit write enable |
| wr8_sel_i | input | 3 | 8-bit write register code |
| wr8_data_i | input | 8 | 8-bit write data |
| wr16_en_i | input | 1 | Pair write enable |
| wr16_sel_i | input | 2 | Pair write code |
| wr16_data_i | input | 16 | Pair write data, high:low |
| xchg_af_i | input | 1 | Toggle live accumulator/flags copy |
| xchg_gp_i | input | 1 | Toggle live BC/DE/HL copy |
| xchg_dehl_i | input | 1 | Toggle DE/HL role swap |

## Verification
Both read ports are combinational. A read result is due in the same cycle as its select and reflects the state left by the previous rising edge. Writes and exchanges take effect at a rising edge, so their effect is due on the read ports in the following cycle, with no extra latency. The bench drives every input just after the falling edge and samples both read ports two nanoseconds later. Before that sample its model has already applied the preceding rising edge, so every cycle compares the settled pre-edge state.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
  typedef enum logic [2:0] {
    R_B = 3'd0, R_C = 3'd1, R_D = 3'd2, R_E = 3'd3,
    R_H = 3'd4, R_L = 3'd5, R_F = 3'd6, R_A = 3'd7
  } reg8_e;

  typedef enum logic [1:0] {
    P_BC = 2'd0, P_DE = 2'd1, P_HL = 2'd2, P_AF = 2'd3
  } reg16_e;

  function automatic logic [2:0] pair_hi(input logic [1:0] p);
    case (p)
      P_BC:    return R_B;
      P_DE:    return R_D;
      P_HL:    return R_H;
      default: return R_A;
    endcase
  endfunction

  function automatic logic [2:0] pair_lo(input logic [1:0] p);
    case (p)
      P_BC:    return R_C;
      P_DE:    return R_E;
      P_HL:    return R_L;
      default: return R_F;
    endcase
  endfunction
endpackage

// File: rtl/rbank_sel.sv
module rbank_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xchg_af_i,
  input  logic xchg_gp_i,
  input  logic xchg_dehl_i,
  output logic af_bank_o,
  output logic gp_bank_o,
  output logic dehl_swap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      af_bank_o   <= 1'b0;
      gp_bank_o   <= 1'b0;
      dehl_swap_o <= 1'b0;
    end else begin
      if (xchg_af_i)   af_bank_o   <= ~af_bank_o;
      if (xchg_gp_i)   gp_bank_o   <= ~gp_bank_o;
      if (xchg_dehl_i) dehl_swap_o <= ~dehl_swap_o;
    end
  end

  // R4
  af_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xchg_af_i |=> $stable(af_bank_o));

  // R5
  gp_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_gp_i |=> gp_bank_o != $past(gp_bank_o));

  // R8
  dehl_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_dehl_i |=> dehl_swap_o != $past(dehl_swap_o));
endmodule

// File: rtl/rbank_map.sv
module rbank_map
  import rbank_pkg::*;
#(
  parameter int SLOT_W = 3,
  localparam int ADDR_W = SLOT_W + 1
) (
  input  logic [SLOT_W-1:0] code_i,
  input  logic              af_bank_i,
  input  logic              gp_bank_i,
  input  logic              dehl_swap_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [SLOT_W-1:0] slot;
  logic              bank;

  always_comb begin
    slot = code_i;
    if (dehl_swap_i) begin
      case (code_i)
        R_D:     slot = R_H;
        R_E:     slot = R_L;
        R_H:     slot = R_D;
        R_L:     slot = R_E;
        default: slot = code_i;
      endcase
    end
    bank   = (code_i == R_A || code_i == R_F) ? af_bank_i : gp_bank_i;
    addr_o = {bank, slot};
  end
endmodule

// File: rtl/rbank_store.sv
module rbank_store #(
  parameter int DW     = 8,
  parameter int ADDR_W = 4,
  parameter int NRD    = 3,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NRD-1:0][ADDR_W-1:0] rd_addr_i,
  output logic [NRD-1:0][DW-1:0]     rd_data_o,
  input  logic                       wr8_en_i,
  input  logic [ADDR_W-1:0]          wr8_addr_i,
  input  logic [DW-1:0]              wr8_data_i,
  input  logic                       wr16_en_i,
  input  logic [ADDR_W-1:0]          wr16_hi_addr_i,
  input  logic [ADDR_W-1:0]          wr16_lo_addr_i,
  input  logic [2*DW-1:0]            wr16_data_i
);
  logic [DEPTH-1:0][DW-1:0] mem;

  always_comb begin
    for (int r = 0; r < NRD; r++) rd_data_o[r] = mem[rd_addr_i[r]];
  end

  // byte write wins over pair write on a shared byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr16_en_i && wr16_hi_addr_i == ADDR_W'(i)) mem[i] <= wr16_data_i[2*DW-1:DW];
        if (wr16_en_i && wr16_lo_addr_i == ADDR_W'(i)) mem[i] <= wr16_data_i[DW-1:0];
        if (wr8_en_i  && wr8_addr_i     == ADDR_W'(i)) mem[i] <= wr8_data_i;
      end
    end
  end

  // R10
  store_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr8_en_i && !wr16_en_i |=> $stable(mem));

  // R9
  wr8_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr8_en_i |=> mem[$past(wr8_addr_i)] == $past(wr8_data_i));

  // R3
  wr16_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr16_en_i && !(wr8_en_i && wr8_addr_i == wr16_lo_addr_i)
    |=> mem[$past(wr16_lo_addr_i)] == $past(wr16_data_i[DW-1:0]));
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
  import rbank_pkg::*;
#(
  parameter int DW = 8,
  localparam int SLOT_W = 3,
  localparam int ADDR_W = SLOT_W + 1,
  localparam int NMAP   = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      rd8_sel_i,
  output logic [DW-1:0]   rd8_data_o,
  input  logic [1:0]      rd16_sel_i,
  output logic [2*DW-1:0] rd16_data_o,
  input  logic            wr8_en_i,
  input  logic [2:0]      wr8_sel_i,
  input  logic [DW-1:0]   wr8_data_i,
  input  logic            wr16_en_i,
  input  logic [1:0]      wr16_sel_i,
  input  logic [2*DW-1:0] wr16_data_i,
  input  logic            xchg_af_i,
  input  logic            xchg_gp_i,
  input  logic            xchg_dehl_i
);
  logic af_bank, gp_bank, dehl_swap;
  logic [NMAP-1:0][SLOT_W-1:0] code;
  logic [NMAP-1:0][ADDR_W-1:0] addr;
  logic [2:0][DW-1:0]          rd_data;

  rbank_sel u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .xchg_af_i   (xchg_af_i),
    .xchg_gp_i   (xchg_gp_i),
    .xchg_dehl_i (xchg_dehl_i),
    .af_bank_o   (af_bank),
    .gp_bank_o   (gp_bank),
    .dehl_swap_o (dehl_swap)
  );

  // 0: rd8, 1/2: rd16 hi/lo, 3: wr8, 4/5: wr16 hi/lo
  always_comb begin
    code[0] = rd8_sel_i;
    code[1] = pair_hi(rd16_sel_i);
    code[2] = pair_lo(rd16_sel_i);
    code[3] = wr8_sel_i;
    code[4] = pair_hi(wr16_sel_i);
    code[5] = pair_lo(wr16_sel_i);
  end

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    rbank_map #(.SLOT_W(SLOT_W)) u_map (
      .code_i      (code[g]),
      .af_bank_i   (af_bank),
      .gp_bank_i   (gp_bank),
      .dehl_swap_i (dehl_swap),
      .addr_o      (addr[g])
    );
  end

  rbank_store #(.DW(DW), .ADDR_W(ADDR_W), .NRD(3)) u_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rd_addr_i      (addr[2:0]),
    .rd_data_o      (rd_data),
    .wr8_en_i       (wr8_en_i),
    .wr8_addr_i     (addr[3]),
    .wr8_data_i     (wr8_data_i),
    .wr16_en_i      (wr16_en_i),
    .wr16_hi_addr_i (addr[4]),
    .wr16_lo_addr_i (addr[5]),
    .wr16_data_i    (wr16_data_i)
  );

  assign rd8_data_o  = rd_data[0];
  assign rd16_data_o = {rd_data[1], rd_data[2]};

  // R3
  pair_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr[1][ADDR_W-1] == addr[2][ADDR_W-1]);
endmodule

// File: tb/dual_bank_regfile_bench.sv
module dual_bank_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rd8_sel = '0;
  logic [7:0]  rd8_data;
  logic [1:0]  rd16_sel = '0;
  logic [15:0] rd16_data;
  logic        wr8_en = 1'b0;
  logic [2:0]  wr8_sel = '0;
  logic [7:0]  wr8_data = '0;
  logic        wr16_en = 1'b0;
  logic [1:0]  wr16_sel = '0;
  logic [15:0] wr16_data = '0;
  logic        x_af = 1'b0, x_gp = 1'b0, x_dh = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  int m_mem[16];
  int m_af = 0, m_gp = 0, m_sw = 0;

  always #5 clk = ~clk;

  dual_bank_regfile u_dual_bank_regfile (
    .clk_i(clk), .rst_ni(rst_n),
    .rd8_sel_i(rd8_sel), .rd8_data_o(rd8_data),
    .rd16_sel_i(rd16_sel), .rd16_data_o(rd16_data),
    .wr8_en_i(wr8_en), .wr8_sel_i(wr8_sel), .wr8_data_i(wr8_data),
    .wr16_en_i(wr16_en), .wr16_sel_i(wr16_sel), .wr16_data_i(wr16_data),
    .xchg_af_i(x_af), .xchg_gp_i(x_gp), .xchg_dehl_i(x_dh)
  );

  // B0 C1 D2 E3 H4 L5 F6 A7; pairs BC0 DE1 HL2 AF3
  function automatic int hi_of(int p);
    int t[4] = '{0, 2, 4, 7};
    return t[p];
  endfunction
  function automatic int lo_of(int p);
    int t[4] = '{1, 3, 5, 6};
    return t[p];
  endfunction
  function automatic int loc(int c);
    int s = c;
    int b = (c >= 6) ? m_af : m_gp;
    if (m_sw != 0 && c >= 2 && c <= 5) s = (c < 4) ? c + 2 : c - 2;
    return b * 8 + s;
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cyc(string req, bit we8, int s8, int d8, bit we16, int s16,
                     int d16, bit xa, bit xg, bit xd, int r8, int r16);
    int a8, ahi, alo;
    @(negedge clk);
    wr8_en = we8;   wr8_sel = 3'(s8);    wr8_data = 8'(d8);
    wr16_en = we16; wr16_sel = 2'(s16);  wr16_data = 16'(d16);
    x_af = xa; x_gp = xg; x_dh = xd;
    rd8_sel = 3'(r8); rd16_sel = 2'(r16);
    #2;
    chk(req, int'(rd8_data), m_mem[loc(r8)]);
    chk(req, int'(rd16_data), (m_mem[loc(hi_of(r16))] << 8) | m_mem[loc(lo_of(r16))]);
    @(posedge clk);
    a8 = loc(s8); ahi = loc(hi_of(s16)); alo = loc(lo_of(s16));
    if (we16) begin
      m_mem[ahi] = (d16 >> 8) & 8'hff;
      m_mem[alo] = d16 & 8'hff;
    end
    if (we8) m_mem[a8] = d8 & 8'hff;
    if (xa) m_af ^= 1;
    if (xg) m_gp ^= 1;
    if (xd) m_sw ^= 1;
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 8; i++) cyc(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, i, i % 4);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset contents
    sweep("R1");
    // R2 byte writes to every name
    for (int i = 0; i < 8; i++) cyc("R2", 1, i, 8'h10 + i, 0, 0, 0, 0, 0, 0, i, 0);
    sweep("R2");
    // R3 pair writes
    for (int p = 0; p < 4; p++) cyc("R3", 0, 0, 0, 1, p, 16'hA100 + p * 16'h0111, 0, 0, 0, 0, p);
    sweep("R3");
    // R4 accumulator/flags exchange
    cyc("R4", 0, 0, 0, 0, 0, 0, 1, 0, 0, 7, 3);
    sweep("R4");
    cyc("R4", 1, 7, 8'h5A, 1, 0, 16'hBEEF, 0, 0, 0, 7, 3);
    cyc("R4", 1, 6, 8'hC3, 0, 0, 0, 0, 0, 0, 6, 3);
    sweep("R4");
    // R6 second exchange restores primary view
    cyc("R6", 0, 0, 0, 0, 0, 0, 1, 0, 0, 7, 3);
    sweep("R6");
    // R5 general group exchange
    cyc("R5", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    sweep("R5");
    for (int p = 0; p < 3; p++) cyc("R5", 0, 0, 0, 1, p, 16'h3300 + p * 16'h1122, 0, 0, 0, 4, p);
    sweep("R5");
    cyc("R6", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1);
    sweep("R6");
    // R7 write with exchange in same cycle
    cyc("R7", 1, 7, 8'h77, 0, 0, 0, 1, 0, 0, 7, 3);
    cyc("R7", 0, 0, 0, 1, 2, 16'h7E7F, 0, 1, 0, 7, 2);
    sweep("R7");
    cyc("R7", 0, 0, 0, 0, 0, 0, 1, 1, 0, 7, 2);
    sweep("R7");
    // R8 DE/HL role swap, including write on the toggle cycle
    cyc("R8", 1, 2, 8'hD2, 0, 0, 0, 0, 0, 1, 2, 1);
    sweep("R8");
    cyc("R8", 0, 0, 0, 1, 1, 16'h4455, 0, 0, 0, 4, 2);
    sweep("R8");
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 1);
    sweep("R8");
    // R9 byte write and pair write on a shared byte
    cyc("R9", 1, 3, 8'h99, 1, 1, 16'h1234, 0, 0, 0, 3, 1);
    cyc("R9", 1, 7, 8'h0F, 1, 3, 16'hF0F0, 0, 0, 0, 7, 3);
    sweep("R9");
    // R10 disabled write ports carry data
    for (int i = 0; i < 8; i++) cyc("R10", 0, i, 8'hEE, 0, i % 4, 16'hDEAD, 0, 0, 0, i, i % 4);
    sweep("R10");
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int r = int'($urandom);
      cyc("R2", r[0], (r >> 1) & 7, (r >> 4) & 255, r[12], (r >> 13) & 3, (r >> 8) & 16'hffff,
          r[15] & r[16], r[17] & r[18], r[19] & r[20], (r >> 21) & 7, (r >> 24) & 3);
    end
    sweep("R6");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule